// File: doc/BRIEF.md
# Buck Converter Fault and Start-Up Supervisor

This block is the digital supervisor that sits beside a synchronous buck regulator's analog front end. It takes the raw flags of the regulator's comparators, passes each through a two-flop synchronizer, and decides from them when the power stage may switch. The flags are: enable request, input-rail good, bias-rail good, feedback over-voltage, feedback under-voltage, valley current limit and over-temperature. It also produces a soft-start reference code that the reference DAC follows, and an open-drain power-good pull-down.

Start-up begins only when enable and both rails are reported good. The reference code then climbs one LSB at a time from zero to full scale. Power-good stays asserted low for a fixed time after enable and while the feedback is outside its window. Each fault has its own qualification rule. Over-voltage and under-voltage must persist for a set number of cycles. Over-current must be seen on a run of consecutive switching cycles. The first two faults and over-current all end in a latch-off. The latch is released only when enable or one of the two rail-good signals changes. A supply dropout and an over-temperature stop the converter without latching, and it restarts by itself once the condition is gone. Every time base is a clock-cycle count set by a parameter.

Top module: `buck_fault_seq`

## Requirements
- R1: While reset is asserted, `stage_en` is 0, `sw_hiz` is 0, `dischg` is 1, `ref_code` is 0 and `pg_pulldown` is 1.
- R2: The stage is enabled only while the synchronized enable, input-rail and bias-rail flags are all 1. It starts within 5 cycles after all three raw inputs are 1. While enable is 0, `dischg` is 1, `sw_hiz` is 0 and `stage_en` is 0.
- R3: On each start, `ref_code` begins at 0 in the first cycle with `stage_en` high. It rises by exactly 1 every `SS_STEP` cycles and reaches 2^`REF_W`−1 exactly (2^`REF_W`−1)·`SS_STEP` cycles after that first cycle. It then holds that value.
- R4: `pg_pulldown` goes to 0 no earlier than `PG_DLY` cycles and no later than `PG_DLY`+6 cycles after the raw enable rises. It stays 0 only while the stage is running after the ramp and neither feedback flag is set. It is never 0 while `stage_en` is 0.
- R5: An over-voltage flag that is held for `OV_DLY` cycles while the stage is enabled latches the converter off: `stage_en`=0, `sw_hiz`=1 and `pg_pulldown`=1. This happens between `OV_DLY` and `OV_DLY`+6 cycles after the raw flag rises. A shorter pulse has no effect, and the count restarts whenever the flag drops.
- R6: An under-voltage flag is counted only after the ramp has completed. Once counted for `UV_DLY` cycles it latches the converter off in the same way as R5. A shorter pulse has no effect, and the flag is ignored during the ramp.
- R7: The latch-off occurs on the `OC_LIMIT`th consecutive `cyc_tick` pulse (9 by default) that finds the current-limit flag set. A tick without the flag resets the run, so `OC_LIMIT`−1 flagged ticks leave the stage running.
- R8: A latch-off persists while enable and both rail flags keep their values. Any change of one of them clears it. The next start begins a fresh ramp with `ref_code` at 0.
- R9: When either rail flag is 0 while enable is 1, the outputs are `stage_en`=0, `sw_hiz`=1 and `pg_pulldown`=1. A new ramp starts with no latch once both rail flags are 1 again.
- R10: Over-temperature gives `stage_en`=0 and `sw_hiz`=1 for as long as the flag is set. A new ramp starts by itself when the flag clears, with no change of enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_a | input | 1 | Raw enable request |
| vin_ok_a | input | 1 | Raw input-rail good flag |
| vcc_ok_a | input | 1 | Raw bias-rail good flag |
| ov_a | input | 1 | Raw feedback over-voltage flag |
| uv_a | input | 1 | Raw feedback under-voltage flag |
| ilim_a | input | 1 | Raw valley current-limit flag |
| hot_a | input | 1 | Raw over-temperature flag |
| cyc_tick | input | 1 | One-cycle strobe per switching cycle, synchronous to clk |
| stage_en | output | 1 | Power stage may switch |
| sw_hiz | output | 1 | Both switches off, switch node floating |
| dischg | output | 1 | Output discharge path on |
| ref_code | output | REF_W | Soft-start reference code |
| pg_pulldown | output | 1 | 1 pulls the open-drain power-good pin low |

## Verification
Two functions can meet in one cycle: the power-good delay expiring, and an over-current latch-off taking effect. The bench provokes this by enabling the block with the current-limit flag held high. It then sweeps the cycle of the ninth switching tick over 21 positions that straddle the power-good expiry. Each run is judged by three things: power-good must never be released while the stage is off, the stage must end latched, and the runs in which power-good is seen released must form an unbroken tail of the sweep.

// File: rtl/bsup_pkg.sv
package bsup_pkg;

    typedef enum logic [2:0] {
        ST_DIS   = 3'd0,
        ST_UVLO  = 3'd1,
        ST_HOT   = 3'd2,
        ST_LATCH = 3'd3,
        ST_RAMP  = 3'd4,
        ST_RUN   = 3'd5
    } sup_state_e;

endpackage

// File: rtl/bsup_sync.sv
module bsup_sync #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = d_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign q_o = sy_q.s2;

endmodule

// File: rtl/bsup_qual.sv
module bsup_qual #(
    parameter int LIMIT = 475
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic flag_i,
    output logic expired_o
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!(arm_i && flag_i))          cnt_d = '0;
        else if (cnt_q != CW'(LIMIT))    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == CW'(LIMIT));

    // R5, R6: expiry only follows a cycle in which the flag was armed and set
    qual_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> $past(arm_i && flag_i));

endmodule

// File: rtl/bsup_occ.sv
module bsup_occ #(
    parameter int LIMIT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic tick_i,
    input  logic ilim_i,
    output logic hit_o
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!arm_i) begin
            run_d = '0;
        end else if (tick_i) begin
            if (!ilim_i)                     run_d = '0;
            else if (run_q != CW'(LIMIT))    run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign hit_o = (run_q == CW'(LIMIT));

    // R7
    occ_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_o) |-> $past(tick_i && ilim_i));

    // R7
    occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(LIMIT));

endmodule

// File: rtl/buck_fault_seq.sv
module buck_fault_seq
    import bsup_pkg::*;
#(
    parameter int REF_W    = 8,
    parameter int SS_STEP  = 294,
    parameter int PG_DLY   = 325000,
    parameter int OV_DLY   = 475,
    parameter int UV_DLY   = 600,
    parameter int OC_LIMIT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_a,
    input  logic             vin_ok_a,
    input  logic             vcc_ok_a,
    input  logic             ov_a,
    input  logic             uv_a,
    input  logic             ilim_a,
    input  logic             hot_a,
    input  logic             cyc_tick,
    output logic             stage_en,
    output logic             sw_hiz,
    output logic             dischg,
    output logic [REF_W-1:0] ref_code,
    output logic             pg_pulldown
);

    localparam int                STP_W   = $clog2(SS_STEP + 1);
    localparam int                PG_W    = $clog2(PG_DLY + 1);
    localparam logic [REF_W-1:0]  REF_TOP = {REF_W{1'b1}};
    localparam int                NSYNC   = 7;

    typedef struct packed {
        sup_state_e        st;
        logic              latch;
        logic [REF_W-1:0]  refc;
        logic [STP_W-1:0]  stp;
        logic [PG_W-1:0]   pgc;
        logic              pg_ok;
        logic              en_p;
        logic              vin_p;
        logic              vcc_p;
    } sup_regs_t;

    sup_regs_t r_d, r_q;

    // synchronized flags
    logic [NSYNC-1:0] raw_vec, syn_vec;
    logic en_s, vin_s, vcc_s, ov_s, uv_s, ilim_s, hot_s;

    assign raw_vec = {hot_a, ilim_a, uv_a, ov_a, vcc_ok_a, vin_ok_a, en_a};
    assign {hot_s, ilim_s, uv_s, ov_s, vcc_s, vin_s, en_s} = syn_vec;

    bsup_sync #(.N(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_vec),
        .q_o   (syn_vec)
    );

    logic active, running, ov_exp, uv_exp, oc_hit;

    assign active  = (r_q.st == ST_RAMP) || (r_q.st == ST_RUN);
    assign running = (r_q.st == ST_RUN);

    bsup_qual #(.LIMIT(OV_DLY)) u_ov_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (active),
        .flag_i    (ov_s),
        .expired_o (ov_exp)
    );

    bsup_qual #(.LIMIT(UV_DLY)) u_uv_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (running),
        .flag_i    (uv_s),
        .expired_o (uv_exp)
    );

    bsup_occ #(.LIMIT(OC_LIMIT)) u_occ (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (active),
        .tick_i (cyc_tick),
        .ilim_i (ilim_s),
        .hit_o  (oc_hit)
    );

    logic chg;
    assign chg = (en_s ^ r_q.en_p) | (vin_s ^ r_q.vin_p) | (vcc_s ^ r_q.vcc_p);

    always_comb begin
        r_d       = r_q;
        r_d.en_p  = en_s;
        r_d.vin_p = vin_s;
        r_d.vcc_p = vcc_s;

        // latch: any change of enable or a rail wins over a new fault
        if (chg) r_d.latch = 1'b0;
        else     r_d.latch = r_q.latch | (active & (ov_exp | uv_exp | oc_hit));

        // power-good delay counted from enable
        if (!en_s)                          r_d.pgc = '0;
        else if (r_q.pgc != PG_W'(PG_DLY))  r_d.pgc = r_q.pgc + 1'b1;

        // state selection in priority order
        if (!en_s)                r_d.st = ST_DIS;
        else if (!(vin_s && vcc_s)) r_d.st = ST_UVLO;
        else if (r_d.latch)       r_d.st = ST_LATCH;
        else if (hot_s)           r_d.st = ST_HOT;
        else begin
            case (r_q.st)
                ST_RAMP: r_d.st = (r_q.refc == REF_TOP) ? ST_RUN : ST_RAMP;
                ST_RUN:  r_d.st = ST_RUN;
                default: r_d.st = ST_RAMP;
            endcase
        end

        // reference ramp
        if (r_d.st == ST_RAMP && r_q.st == ST_RAMP) begin
            if (r_q.stp == STP_W'(SS_STEP - 1)) begin
                r_d.stp  = '0;
                r_d.refc = r_q.refc + 1'b1;
            end else begin
                r_d.stp  = r_q.stp + 1'b1;
            end
        end else if (r_d.st == ST_RUN) begin
            r_d.stp  = '0;
            r_d.refc = REF_TOP;
        end else begin
            r_d.stp  = '0;
            r_d.refc = '0;
        end

        r_d.pg_ok = (r_d.st == ST_RUN) && (r_d.pgc == PG_W'(PG_DLY)) && !ov_s && !uv_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_DIS;
        end else begin
            r_q       <= r_d;
        end
    end

    assign stage_en    = active;
    assign sw_hiz      = (r_q.st == ST_UVLO) || (r_q.st == ST_HOT) || (r_q.st == ST_LATCH);
    assign dischg      = (r_q.st == ST_DIS);
    assign ref_code    = r_q.refc;
    assign pg_pulldown = !r_q.pg_ok;

    // R3
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RAMP && $past(r_q.st == ST_RAMP)) |->
        (r_q.refc == $past(r_q.refc) || r_q.refc == $past(r_q.refc) + 1'b1));

    // R4
    pg_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pg_ok |-> (stage_en && r_q.pgc == PG_W'(PG_DLY)));

    // R2
    dis_dischg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> dischg);

    // R5
    ov_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_exp |=> !stage_en);

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.latch && !chg) |=> r_q.latch);

endmodule

// File: tb/buck_fault_seq_tb_top.sv
module buck_fault_seq_tb_top;

    localparam int REF_W    = 4;
    localparam int SS_STEP  = 3;
    localparam int PG_DLY   = 80;
    localparam int OV_DLY   = 20;
    localparam int UV_DLY   = 25;
    localparam int OC_LIMIT = 9;
    localparam int FULL     = (1 << REF_W) - 1;
    localparam int NOFF     = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a = 0, vin_ok_a = 0, vcc_ok_a = 0, ov_a = 0, uv_a = 0, ilim_a = 0, hot_a = 0, cyc_tick = 0;
    logic stage_en, sw_hiz, dischg, pg_pulldown;
    logic [REF_W-1:0] ref_code;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    buck_fault_seq #(
        .REF_W(REF_W), .SS_STEP(SS_STEP), .PG_DLY(PG_DLY),
        .OV_DLY(OV_DLY), .UV_DLY(UV_DLY), .OC_LIMIT(OC_LIMIT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en_a(en_a), .vin_ok_a(vin_ok_a), .vcc_ok_a(vcc_ok_a),
        .ov_a(ov_a), .uv_a(uv_a), .ilim_a(ilim_a), .hot_a(hot_a), .cyc_tick(cyc_tick),
        .stage_en(stage_en), .sw_hiz(sw_hiz), .dischg(dischg),
        .ref_code(ref_code), .pg_pulldown(pg_pulldown)
    );

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic wait_off(output int cyc);
        cyc = 0;
        while (stage_en && cyc < 200) begin
            step();
            cyc++;
        end
    endtask

    task automatic wait_pg(output int cyc);
        cyc = 0;
        while (pg_pulldown && cyc < 300) begin
            step();
            cyc++;
        end
    endtask

    task automatic wait_on(output int cyc);
        cyc = 0;
        while (!stage_en && cyc < 50) begin
            step();
            cyc++;
        end
    endtask

    task automatic tick(bit f);
        ilim_a = f;
        step(2);
        cyc_tick = 1'b1;
        step(1);
        cyc_tick = 1'b0;
        step(1);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        int t, t0, tfull, tpg, prev, held, bad_step, bad_hold;
        bit seen [NOFF];

        // R1 reset state
        rst_n = 1'b0;
        step(4);
        chk(stage_en == 0, "R1 stage_en", stage_en, 0);
        chk(dischg == 1, "R1 dischg", dischg, 1);
        chk(sw_hiz == 0, "R1 sw_hiz", sw_hiz, 0);
        chk(ref_code == 0, "R1 ref_code", ref_code, 0);
        chk(pg_pulldown == 1, "R1 pg_pulldown", pg_pulldown, 1);
        rst_n = 1'b1;
        step(2);

        // R2 / R9: bias rail missing keeps the stage off
        en_a = 1; vin_ok_a = 1; vcc_ok_a = 0;
        step(30);
        chk(stage_en == 0, "R2 no start without bias rail", stage_en, 0);
        chk(sw_hiz == 1, "R9 floating node on rail loss", sw_hiz, 1);
        en_a = 0; vcc_ok_a = 1;
        step(10);
        chk(stage_en == 0, "R2 disabled stage", stage_en, 0);
        chk(dischg == 1, "R2 disabled discharge", dischg, 1);
        chk(sw_hiz == 0, "R2 disabled node not floating", sw_hiz, 0);

        // R2 / R3 / R4 start-up measurement
        en_a = 1;
        t = 0; t0 = -1; tfull = -1; tpg = -1; prev = 0; held = 0; bad_step = 0; bad_hold = 0;
        while (t < 200) begin
            step();
            t++;
            if (stage_en && t0 < 0) begin
                t0 = t; prev = ref_code; held = 0;
            end
            if (t0 >= 0 && tfull < 0) begin
                if (ref_code != prev) begin
                    if (ref_code != prev + 1) bad_step++;
                    if (held != SS_STEP) bad_hold++;
                    held = 1;
                    prev = ref_code;
                end else begin
                    held++;
                end
                if (ref_code == FULL) tfull = t;
            end
            if (!pg_pulldown && tpg < 0) tpg = t;
        end
        chk(t0 >= 1 && t0 <= 5, "R2 start latency", t0, 3);
        chk(bad_step == 0, "R3 unit steps", bad_step, 0);
        chk(bad_hold == 0, "R3 step period", bad_hold, 0);
        chk(tfull - t0 == FULL * SS_STEP, "R3 ramp length", tfull - t0, FULL * SS_STEP);
        chk(ref_code == FULL, "R3 hold full scale", ref_code, FULL);
        chk(tpg >= PG_DLY && tpg <= PG_DLY + 6, "R4 power-good delay", tpg, PG_DLY + 2);

        // R5 short and interrupted over-voltage pulses
        ov_a = 1; step(OV_DLY - 4); ov_a = 0;
        step(30);
        chk(stage_en == 1, "R5 short OV ignored", stage_en, 1);
        ov_a = 1; step(OV_DLY - 4); ov_a = 0; step(3);
        ov_a = 1; step(OV_DLY - 4); ov_a = 0;
        step(30);
        chk(stage_en == 1, "R5 OV timer restarts", stage_en, 1);
        chk(pg_pulldown == 0, "R4 power-good back after OV clears", pg_pulldown, 0);

        // R5 qualified over-voltage
        ov_a = 1;
        wait_off(c);
        chk(c >= OV_DLY && c <= OV_DLY + 6, "R5 OV latch delay", c, OV_DLY + 3);
        chk(sw_hiz == 1, "R5 switches off", sw_hiz, 1);
        chk(pg_pulldown == 1, "R5 power-good low", pg_pulldown, 1);
        ov_a = 0;
        step(40);
        chk(stage_en == 0, "R8 latch holds", stage_en, 0);
        en_a = 0; step(6); en_a = 1;
        wait_on(c);
        chk(stage_en == 1, "R8 enable toggle restarts", stage_en, 1);
        chk(ref_code == 0, "R8 fresh ramp", ref_code, 0);
        wait_pg(c);

        // R6 under-voltage
        uv_a = 1; step(UV_DLY - 4); uv_a = 0;
        step(30);
        chk(stage_en == 1, "R6 short UV ignored", stage_en, 1);
        uv_a = 1;
        wait_off(c);
        chk(c >= UV_DLY && c <= UV_DLY + 6, "R6 UV latch delay", c, UV_DLY + 3);
        chk(sw_hiz == 1, "R6 switches off", sw_hiz, 1);
        vin_ok_a = 0; step(6); vin_ok_a = 1;
        step(40);
        chk(stage_en == 1, "R6 UV ignored during ramp", stage_en, 1);
        wait_off(c);
        chk(stage_en == 0, "R6 UV latches after ramp", stage_en, 0);
        uv_a = 0;
        vcc_ok_a = 0; step(6); vcc_ok_a = 1;
        wait_on(c);
        chk(stage_en == 1, "R8 bias toggle restarts", stage_en, 1);
        wait_pg(c);

        // R7 over-current run
        repeat (OC_LIMIT - 1) tick(1);
        step(10);
        chk(stage_en == 1, "R7 eight ticks keep running", stage_en, 1);
        tick(1);
        step(2);
        chk(stage_en == 0, "R7 ninth tick latches", stage_en, 0);
        ilim_a = 0;
        en_a = 0; step(6); en_a = 1;
        wait_pg(c);
        repeat (5) tick(1);
        tick(0);
        repeat (OC_LIMIT - 1) tick(1);
        step(10);
        chk(stage_en == 1, "R7 clean tick resets run", stage_en, 1);
        tick(0);
        ilim_a = 0;

        // R9 supply dropout
        vcc_ok_a = 0;
        step(4);
        chk(stage_en == 0, "R9 stage off", stage_en, 0);
        chk(sw_hiz == 1, "R9 node floating", sw_hiz, 1);
        chk(pg_pulldown == 1, "R9 power-good low", pg_pulldown, 1);
        vcc_ok_a = 1;
        wait_on(c);
        chk(stage_en == 1 && c <= 6, "R9 automatic restart", c, 3);
        wait_pg(c);
        chk(pg_pulldown == 0, "R9 power-good returns", pg_pulldown, 0);

        // R10 over-temperature
        hot_a = 1;
        step(4);
        chk(stage_en == 0, "R10 stage off", stage_en, 0);
        chk(sw_hiz == 1, "R10 node floating", sw_hiz, 1);
        step(40);
        chk(stage_en == 0, "R10 stays off while hot", stage_en, 0);
        hot_a = 0;
        step(5);
        chk(stage_en == 1, "R10 automatic restart", stage_en, 1);

        // R4 / R7 collision sweep: power-good expiry vs over-current latch
        for (int off = 0; off < NOFF; off++) begin
            int viol;
            int first;
            rst_n = 0; en_a = 0; ilim_a = 0; cyc_tick = 0;
            step(3);
            rst_n = 1; vin_ok_a = 1; vcc_ok_a = 1;
            step(5);
            en_a = 1; ilim_a = 1;
            viol = 0;
            seen[off] = 0;
            first = PG_DLY - 8 + off - 32;
            for (int k = 0; k < 160; k++) begin
                cyc_tick = (k >= first) && ((k - first) % 4 == 0) && ((k - first) / 4 < OC_LIMIT);
                step();
                if (!pg_pulldown) seen[off] = 1;
                if (!pg_pulldown && !stage_en) viol++;
            end
            cyc_tick = 0;
            chk(viol == 0, "R4 power-good never with stage off", viol, 0);
            chk(stage_en == 0, "R7 sweep run latched", stage_en, 0);
        end
        chk(seen[0] == 0, "R4 early latch blocks power-good", seen[0], 0);
        chk(seen[NOFF-1] == 1, "R4 late latch after power-good", seen[NOFF-1], 1);
        begin
            int breaks = 0;
            for (int k = 1; k < NOFF; k++) if (seen[k-1] && !seen[k]) breaks++;
            chk(breaks == 0, "R7 sweep monotonic", breaks, 0);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule